// File: doc/BRIEF.md
# Wait-Acknowledged External Bus Slave

This block lets an external bus master reach an internal register space through a synchronous, strobe-based interface. The master starts a transfer by pulling chip select low together with either the read enable or the write enable, all active low. The slave answers by raising a wait line on the next clock edge. It holds wait high until the internal access is complete. The master keeps the bus driven for as long as wait stays high, so a transfer lasts as many cycles as the slave needs and not a fixed access time.

On the internal side, the slave takes a copy of the address and write data at the moment it detects the request. It issues a one-cycle read or write strobe with that copy and waits a configurable number of cycles (`ACC_LAT`, at least one). For a read, it loads the returned word into its read data register one cycle before wait falls. Once wait has dropped, the slave accepts nothing more until chip select has been seen high.

Top module: `wait_bus_slave`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `bus_wait`, `reg_wr_en` and `reg_rd_en` are 0 and `bus_rdata` is 0.
- R2: While `bus_cs_n` is 1, the levels on `bus_rd_n` and `bus_wr_n` cause no `bus_wait` and no internal strobe.
- R3: When the slave is ready and samples `bus_cs_n`=0 with `bus_rd_n`=0 or `bus_wr_n`=0 on a clock edge, `bus_wait` is 1 from that edge on.
- R4: Each assertion of `bus_wait` lasts exactly `ACC_LAT`+1 cycles.
- R5: A write request produces exactly one `reg_wr_en` pulse, in the first wait cycle. It carries the address and data that were present when the request was detected.
- R6: `reg_addr` and `reg_wdata` keep the values sampled at detection for the whole wait period, even when the bus address or data change.
- R7: A read request produces exactly one `reg_rd_en` pulse, in the first wait cycle. In the last wait cycle, `bus_rdata` holds the word `reg_rdata` returned for the sampled address.
- R8: If both enables are low with chip select low, the transfer is a write; no read strobe is issued.
- R9: After `bus_wait` falls, no new transfer starts while `bus_cs_n` stays 0. A new request is accepted only after at least one cycle with `bus_cs_n`=1.
- R10: `bus_rdata` keeps its value through write transfers and idle cycles. It changes only at the end of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read enable, active low |
| bus_wr_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Write data from the master |
| bus_rdata | output | DATA_W | Registered read data to the master |
| bus_wait | output | 1 | High while a transfer is in progress |
| reg_addr | output | ADDR_W | Sampled address to the register space |
| reg_wdata | output | DATA_W | Sampled write data to the register space |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Word returned by the register space for `reg_addr` |

## Verification
A wrong sequencer state shows up at the wait line itself. Wait would rise a cycle late, hold one cycle too long or too short, or rise again while chip select is still low after a transfer. Each of these is visible within one cycle of its cause, because the bench's reference model predicts wait on every edge. A stale or re-sampled address copy would send the strobe or the read return to the wrong location. That is seen at the strobe cycle, or at the latest when the affected location is read back.

// File: rtl/slv_pkg.sv
package slv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } slv_state_e;
endpackage

// File: rtl/slv_req_detect.sv
module slv_req_detect (
  input  logic ready,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic req,
  output logic req_is_wr
);
  // chip select gates both enables; write wins when both are low
  always_comb begin
    req       = ready && !cs_n && (!rd_n || !wr_n);
    req_is_wr = !wr_n;
  end
endmodule

// File: rtl/slv_lat_timer.sv
module slv_lat_timer #(
  parameter int ACC_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic last
);
  localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(ACC_LAT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = (cnt_q == LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (run && !last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/slv_capture.sv
module slv_capture #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end
endmodule

// File: rtl/wait_bus_slave.sv
module wait_bus_slave
  import slv_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int ACC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  input  logic [DATA_W-1:0] reg_rdata
);
  slv_state_e        state_q;
  logic              req, req_is_wr, t_last;
  logic              is_wr_q, wait_q, wr_en_q, rd_en_q;
  logic [DATA_W-1:0] rdata_q;

  slv_req_detect u_det (
    .ready     (state_q == ST_IDLE),
    .cs_n      (bus_cs_n),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .req       (req),
    .req_is_wr (req_is_wr)
  );

  slv_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .load   (req),
    .addr_i (bus_addr),
    .data_i (bus_wdata),
    .addr_q (reg_addr),
    .data_q (reg_wdata)
  );

  slv_lat_timer #(.ACC_LAT(ACC_LAT)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (req),
    .run   (state_q == ST_BUSY),
    .last  (t_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      wait_q  <= 1'b0;
      wr_en_q <= 1'b0;
      rd_en_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      rd_en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req) begin
          state_q <= ST_BUSY;
          wait_q  <= 1'b1;
          is_wr_q <= req_is_wr;
          wr_en_q <= req_is_wr;
          rd_en_q <= !req_is_wr;
        end
        ST_BUSY: if (t_last) begin
          state_q <= ST_DATA;
          if (!is_wr_q) rdata_q <= reg_rdata;
        end
        ST_DATA: begin
          state_q <= ST_DONE;
          wait_q  <= 1'b0;
        end
        ST_DONE: if (bus_cs_n) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_wait  = wait_q;
  assign bus_rdata = rdata_q;
  assign reg_wr_en = wr_en_q;
  assign reg_rd_en = rd_en_q;
endmodule

// File: rtl/wait_bus_slave_chk.sv
module wait_bus_slave_chk #(
  parameter int ADDR_W  = 4,
  parameter int ACC_LAT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              bus_wait,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [ADDR_W-1:0] reg_addr
);
  int unsigned wlen;

  always_ff @(posedge clk) begin
    if (rst || !bus_wait) wlen <= 0;
    else                  wlen <= wlen + 1;
  end

  // R2
  wait_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wait) |-> $past(!bus_cs_n));

  // R3
  wait_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wait) |-> $past(!bus_rd_n || !bus_wr_n));

  // R4
  wait_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wait) |-> (wlen == ACC_LAT + 1));

  // R5
  wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $rose(bus_wait));

  // R7
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |-> $rose(bus_wait));

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr_en, reg_rd_en}));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wait && $past(bus_wait)) |-> $stable(reg_addr));

  // R9
  gap_after_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_wait) |=> !bus_wait);
endmodule

bind wait_bus_slave wait_bus_slave_chk #(.ADDR_W(ADDR_W), .ACC_LAT(ACC_LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_cs_n  (bus_cs_n),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_wait  (bus_wait),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr)
);

// File: tb/wait_bus_slave_tb.sv
module wait_bus_slave_tb;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] bus_rdata, reg_wdata, reg_rdata;
  logic [AW-1:0] reg_addr;
  logic bus_wait, reg_wr_en, reg_rd_en;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wait_bus_slave #(.ADDR_W(AW), .DATA_W(DW), .ACC_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
  );

  // register space seen by the slave
  logic [DW-1:0] env_mem [16];
  initial for (int i = 0; i < 16; i++) env_mem[i] = '0;
  assign reg_rdata = env_mem[reg_addr];
  always @(posedge clk) if (reg_wr_en) env_mem[reg_addr] <= reg_wdata;

  // behavioural reference model
  logic [DW-1:0] m_mem [16];
  initial for (int i = 0; i < 16; i++) m_mem[i] = '0;
  int m_left = 0;
  bit m_block = 0, m_is_wr = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic e_wait = 0, e_wr = 0, e_rd = 0;
  logic [DW-1:0] e_rdata = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_block = 0; e_wait = 0; e_wr = 0; e_rd = 0; e_rdata = '0;
    end else begin
      e_wr = 0; e_rd = 0;
      if (m_left > 0) begin
        if (m_left == 2 && !m_is_wr) e_rdata = m_mem[m_addr];
        if (m_left == 1) begin e_wait = 0; m_block = 1; end
        m_left = m_left - 1;
      end else if (m_block) begin
        if (cs_n) m_block = 0;
      end else if (!cs_n && (!rd_n || !wr_n)) begin
        m_is_wr = !wr_n; m_addr = addr; m_wdata = wdata;
        m_left = LAT + 1; e_wait = 1;
        if (!wr_n) begin m_mem[addr] = wdata; e_wr = 1; end
        else e_rd = 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 wait", bus_wait, e_wait);
      chk("R5 wr strobe", reg_wr_en, e_wr);
      chk("R7 rd strobe", reg_rd_en, e_rd);
      chk("R10 rdata", bus_rdata, e_rdata);
      if (e_wait) begin
        chk("R6 addr hold", reg_addr, m_addr);
        if (m_is_wr) chk("R6 wdata hold", reg_wdata, m_wdata);
      end
    end
  end

  logic [DW-1:0] sb [16];
  initial for (int i = 0; i < 16; i++) sb[i] = '0;

  task automatic xfer(input bit is_wr, input bit both, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int hold, input bit wiggle);
    @(negedge clk);
    cs_n = 0; addr = a; wdata = d;
    if (both) begin rd_n = 0; wr_n = 0; end
    else if (is_wr) wr_n = 0;
    else rd_n = 0;
    @(negedge clk);
    chk("R3 wait rise", bus_wait, 1'b1);
    if (wiggle) begin addr = ~a; wdata = ~d; end
    while (bus_wait) @(negedge clk);
    if (is_wr || both) sb[a] = d;
    else chk("R7 read data", bus_rdata, sb[a]);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R9 no restart", bus_wait, 1'b0);
    end
    cs_n = 1; rd_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 wait in reset", bus_wait, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R1 wait", bus_wait, 1'b0);
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 strobes", {reg_wr_en, reg_rd_en}, 2'b00);

    // R2: enables toggled with chip select high
    rd_n = 0; wr_n = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R2 ignored", {bus_wait, reg_wr_en, reg_rd_en}, 3'b000);
    end
    rd_n = 1; wr_n = 1;

    xfer(1, 0, 4'h3, 8'hA5, 0, 0);
    xfer(1, 0, 4'h7, 8'h3C, 0, 0);
    xfer(1, 0, 4'h0, 8'hFF, 1, 0);
    xfer(1, 0, 4'hF, 8'h01, 0, 0);
    xfer(0, 0, 4'h3, 8'h00, 0, 0);
    xfer(0, 0, 4'hF, 8'h00, 0, 0);
    // R6: bus changes during wait
    xfer(0, 0, 4'h7, 8'h00, 0, 1);
    xfer(1, 0, 4'h5, 8'h77, 0, 1);
    xfer(0, 0, 4'h5, 8'h00, 0, 0);
    chk("R6 env write", env_mem[5], 8'h77);
    // R8: both enables low is a write
    xfer(0, 1, 4'h9, 8'h5A, 0, 0);
    xfer(0, 0, 4'h9, 8'h00, 0, 0);
    // R9: chip select kept low after completion
    xfer(0, 0, 4'h0, 8'h00, 4, 0);
    // R10: rdata holds through a write
    xfer(1, 0, 4'h2, 8'hC3, 0, 0);
    chk("R10 rdata held", bus_rdata, 8'hFF);
    xfer(0, 0, 4'h2, 8'h00, 0, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule